// File: doc/BRIEF.md
# Indirect Meter Table Access Port

This block lets a 32-bit register bus read and write a table of 96-bit rate-meter entries that are too wide for a single bus transfer. To write, software first loads three 32-bit staging words. It then writes any value to the trigger address of the chosen entry. The block issues one table write that carries all 96 staged bits at once. To read, software reads the trigger address of an entry. The block fetches the entry from the table and loads it into three read-back words in a single step. Software then reads those words at its own pace.

The write staging words and the read-back words are kept apart, so a fetch never disturbs data that software has staged for a write. The block also decodes the fields of the entry held in the read-back words and drives them on dedicated outputs: enable flag, colour mode, exponent and mantissa. The table RAM sits behind a request/grant handshake and may hold off a transfer for any number of cycles. While a transfer is pending, the bus sees the block as not ready.

Top module: `meter_table_port`

## Requirements
- R1: After reset, all staging and read-back words are zero, `bus_ready` is 1, `tbl_req` is 0 and `rb_enable` is 0.
- R2: The write staging words sit at byte addresses 0x00, 0x04 and 0x08 (low word first). A write there is stored, and a read of them returns the stored value on `bus_rdata` in the cycle after the read is accepted.
- R3: A write to trigger address `TRIG_BASE + 4*i`, with i below `NUM_ENTRIES`, raises `tbl_req` with `tbl_we`=1, `tbl_addr`=i and `tbl_wdata`={word2,word1,word0}. All of these stay stable until a cycle in which `tbl_gnt` is 1.
- R4: A read of a valid trigger address raises `tbl_req` with `tbl_we`=0 and `tbl_addr`=i. The entry on `tbl_rdata` one cycle after the grant is loaded into all three read-back words (0x10, 0x14, 0x18, low word first) together. The read-back words change at no other time.
- R5: `bus_ready` is 0 from the cycle after a valid trigger is accepted until the transfer ends. A bus access presented while `bus_ready` is 0 has no effect.
- R6: A read trigger leaves the write staging words unchanged.
- R7: An aligned trigger address whose index is `NUM_ENTRIES` or more is ignored. It raises no table request, keeps `bus_ready` at 1 and reads back zero.
- R8: The decoded outputs follow the read-back entry bits: `rb_enable` is bit 95, `rb_mode` bits 91:90, `rb_mantissa` bits 89:78 and `rb_exponent` bits 77:72. In word 2 these are bit 31, bits 27:26, bits 25:14 and bits 13:8.
- R9: Committing an all-zero entry invalidates it. A later fetch of that entry gives `rb_enable` = 0.
- R10: Reads of a valid trigger address and of unmapped addresses return zero on `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, accepted when bus_ready is 1 |
| bus_rd | input | 1 | Read strobe, accepted when bus_ready is 1 and bus_wr is 0 |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after the read is accepted |
| bus_ready | output | 1 | 1 when the block can accept an access |
| tbl_req | output | 1 | Table transfer request |
| tbl_we | output | 1 | 1 for a table write, 0 for a fetch |
| tbl_addr | output | IDX_W | Entry index |
| tbl_wdata | output | 96 | Entry to write |
| tbl_gnt | input | 1 | Table grant, completes the request in the cycle it is seen |
| tbl_rdata | input | 96 | Fetched entry, valid one cycle after a read grant |
| rb_enable | output | 1 | Enable flag of the read-back entry |
| rb_mode | output | 2 | Colour mode of the read-back entry |
| rb_exponent | output | 6 | Rate exponent of the read-back entry |
| rb_mantissa | output | 12 | Rate mantissa of the read-back entry |

## Verification
A register read returns its data one edge after acceptance. The bench therefore samples `bus_rdata` at the falling edge that follows the accepting rising edge. `bus_ready` falls one edge after a valid trigger is accepted, and it is checked at that same falling edge. A table write completes at the grant edge. A fetch completes one edge later, when the read-back words and the decoded field outputs change together. The bench waits for `bus_ready` to return to 1 before it reads any result. Grants arrive after random delays, and during the blocked-access test they are held off on purpose.

// File: rtl/mtp_pkg.sv
package mtp_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned ENTRY_W = 96;

  typedef struct packed {
    logic        en;
    logic        rsvd;
    logic        len_type;
    logic        coupling;
    logic [1:0]  mode;
    logic [11:0] mantissa;
    logic [5:0]  exponent;
    logic [23:0] max_burst;
    logic [23:0] stamp;
    logic [23:0] credits;
  } meter_entry_t;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_WSTAGE,
    ACC_RSTAGE,
    ACC_TRIG,
    ACC_TRIG_OOB
  } acc_kind_t;

  function automatic meter_entry_t pack_words(input logic [WORD_W-1:0] w2,
                                              input logic [WORD_W-1:0] w1,
                                              input logic [WORD_W-1:0] w0);
    return meter_entry_t'({w2, w1, w0});
  endfunction

  function automatic logic [WORD_W-1:0] entry_word(input meter_entry_t e,
                                                   input logic [1:0] sel);
    logic [ENTRY_W-1:0] flat;
    flat = e;
    case (sel)
      2'd0:    return flat[31:0];
      2'd1:    return flat[63:32];
      2'd2:    return flat[95:64];
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/mtp_addr_decode.sv
module mtp_addr_decode
  import mtp_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned NUM_ENTRIES = 12,
  parameter logic [ADDR_W-1:0] TRIG_BASE = 16'h0100,
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_t         kind,
  output logic [1:0]        word_sel,
  output logic [IDX_W-1:0]  idx
);

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] idx_full;
  logic              aligned;
  logic              in_stage;

  assign off      = addr - TRIG_BASE;
  assign idx_full = off >> 2;
  assign aligned  = (addr[1:0] == 2'b00);
  assign in_stage = ((addr >> 5) == '0);
  assign word_sel = addr[3:2];
  assign idx      = idx_full[IDX_W-1:0];

  always_comb begin
    kind = ACC_NONE;
    if (aligned) begin
      if (addr >= TRIG_BASE) begin
        kind = (idx_full < ADDR_W'(NUM_ENTRIES)) ? ACC_TRIG : ACC_TRIG_OOB;
      end else if (in_stage && (addr[3:2] != 2'd3)) begin
        kind = addr[4] ? ACC_RSTAGE : ACC_WSTAGE;
      end
    end
  end

endmodule

// File: rtl/mtp_xfer_ctrl.sv
module mtp_xfer_ctrl
  import mtp_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_wr,
  input  logic               start_rd,
  input  logic [IDX_W-1:0]   idx,
  input  meter_entry_t       stage_entry,
  input  logic               tbl_gnt,
  input  logic [ENTRY_W-1:0] tbl_rdata,
  output logic               tbl_req,
  output logic               tbl_we,
  output logic [IDX_W-1:0]   tbl_addr,
  output logic [ENTRY_W-1:0] tbl_wdata,
  output logic               idle,
  output logic               rb_load,
  output meter_entry_t       rb_data
);

  typedef enum logic [1:0] {X_IDLE, X_REQ, X_DATA} xstate_t;
  xstate_t state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= X_IDLE;
      tbl_we    <= 1'b0;
      tbl_addr  <= '0;
      tbl_wdata <= '0;
    end else begin
      case (state)
        X_IDLE: if (start_wr || start_rd) begin
          state     <= X_REQ;
          tbl_we    <= start_wr;
          tbl_addr  <= idx;
          tbl_wdata <= start_wr ? stage_entry : '0;
        end
        X_REQ: if (tbl_gnt) state <= tbl_we ? X_IDLE : X_DATA;
        X_DATA: state <= X_IDLE;
        default: state <= X_IDLE;
      endcase
    end
  end

  assign tbl_req = (state == X_REQ);
  assign idle    = (state == X_IDLE);
  assign rb_load = (state == X_DATA);
  assign rb_data = meter_entry_t'(tbl_rdata);

  // R3: request and its payload held until granted
  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_req && !tbl_gnt) |=> (tbl_req && $stable(tbl_addr) &&
                               $stable(tbl_we) && $stable(tbl_wdata)));

  // R4: a load only follows a granted fetch
  a_r4_load_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    rb_load |-> $past(tbl_req && tbl_gnt && !tbl_we));

endmodule

// File: rtl/mtp_field_view.sv
module mtp_field_view
  import mtp_pkg::*;
(
  input  meter_entry_t entry,
  output logic         f_enable,
  output logic [1:0]   f_mode,
  output logic [5:0]   f_exponent,
  output logic [11:0]  f_mantissa
);

  assign f_enable   = entry.en;
  assign f_mode     = entry.mode;
  assign f_exponent = entry.exponent;
  assign f_mantissa = entry.mantissa;

endmodule

// File: rtl/meter_table_port.sv
module meter_table_port
  import mtp_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned NUM_ENTRIES = 12,
  parameter logic [ADDR_W-1:0] TRIG_BASE = 16'h0100,
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int unsigned NWORDS = ENTRY_W / WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  input  logic               bus_wr,
  input  logic               bus_rd,
  output logic [31:0]        bus_rdata,
  output logic               bus_ready,
  output logic               tbl_req,
  output logic               tbl_we,
  output logic [IDX_W-1:0]   tbl_addr,
  output logic [95:0]        tbl_wdata,
  input  logic               tbl_gnt,
  input  logic [95:0]        tbl_rdata,
  output logic               rb_enable,
  output logic [1:0]         rb_mode,
  output logic [5:0]         rb_exponent,
  output logic [11:0]        rb_mantissa
);

  acc_kind_t        kind;
  logic [1:0]       word_sel;
  logic [IDX_W-1:0] idx;
  logic             acc_wr, acc_rd;
  logic             start_wr, start_rd;
  logic             rb_load;
  meter_entry_t     rb_data, rb_q, stage_entry;
  logic [WORD_W-1:0] wstage [NWORDS];
  logic [ENTRY_W-1:0] wflat;
  logic [31:0]      rd_mux;

  mtp_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_ENTRIES(NUM_ENTRIES), .TRIG_BASE(TRIG_BASE)
  ) u_dec (
    .addr(bus_addr), .kind(kind), .word_sel(word_sel), .idx(idx)
  );

  assign acc_wr   = bus_wr && bus_ready;
  assign acc_rd   = bus_rd && !bus_wr && bus_ready;
  assign start_wr = acc_wr && (kind == ACC_TRIG);
  assign start_rd = acc_rd && (kind == ACC_TRIG);

  // write staging words
  for (genvar g = 0; g < NWORDS; g++) begin : g_wstage
    always_ff @(posedge clk) begin
      if (!rst_n)
        wstage[g] <= '0;
      else if (acc_wr && kind == ACC_WSTAGE && word_sel == 2'(g))
        wstage[g] <= bus_wdata;
    end
    assign wflat[g*WORD_W +: WORD_W] = wstage[g];
  end

  assign stage_entry = pack_words(wstage[2], wstage[1], wstage[0]);

  mtp_xfer_ctrl #(.IDX_W(IDX_W)) u_xfer (
    .clk(clk), .rst_n(rst_n),
    .start_wr(start_wr), .start_rd(start_rd), .idx(idx),
    .stage_entry(stage_entry),
    .tbl_gnt(tbl_gnt), .tbl_rdata(tbl_rdata),
    .tbl_req(tbl_req), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata),
    .idle(bus_ready), .rb_load(rb_load), .rb_data(rb_data)
  );

  // read-back words, loaded as one 96-bit unit
  always_ff @(posedge clk) begin
    if (!rst_n)       rb_q <= '0;
    else if (rb_load) rb_q <= rb_data;
  end

  always_comb begin
    case (kind)
      ACC_WSTAGE: rd_mux = wstage[word_sel];
      ACC_RSTAGE: rd_mux = entry_word(rb_q, word_sel);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (acc_rd) bus_rdata <= rd_mux;
  end

  mtp_field_view u_view (
    .entry(rb_q), .f_enable(rb_enable), .f_mode(rb_mode),
    .f_exponent(rb_exponent), .f_mantissa(rb_mantissa)
  );

  // R5: the bus is held off while the table is requested
  a_r5_busy_while_req: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_req |-> !bus_ready);

  // R5: accesses while not ready leave staging words alone
  a_r5_blocked_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ready |=> $stable(wflat));

  // R4: read-back words move only on a load
  a_r4_rb_atomic: assert property (@(posedge clk) disable iff (!rst_n)
    !rb_load |=> $stable(rb_q));

  // R6: a fetch trigger keeps staged write data
  a_r6_fetch_keeps_stage: assert property (@(posedge clk) disable iff (!rst_n)
    start_rd |=> $stable(wflat));

  // R7: an out-of-range trigger starts nothing
  a_r7_oob_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_wr || acc_rd) && kind == ACC_TRIG_OOB) |=> (!tbl_req && bus_ready));

  // R10: trigger and unmapped reads return zero
  a_r10_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && kind != ACC_WSTAGE && kind != ACC_RSTAGE) |=> (bus_rdata == 32'h0));

endmodule

// File: tb/sim_meter_table_port.sv
`timescale 1ns/1ps
module sim_meter_table_port;

  localparam int NENT = 12;
  localparam logic [15:0] TBASE = 16'h0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic        tbl_req, tbl_we, tbl_gnt;
  logic [3:0]  tbl_addr;
  logic [95:0] tbl_wdata;
  logic [95:0] ram_rdata = '0;
  logic        rb_enable;
  logic [1:0]  rb_mode;
  logic [5:0]  rb_exponent;
  logic [11:0] rb_mantissa;

  int checks = 0, errors = 0;
  int grants = 0;
  logic last_we = 1'b0;
  logic [3:0] last_addr = '0;
  logic gnt_en = 1'b1, gnt_r = 1'b0;
  logic [95:0] mem [NENT];
  logic [95:0] exp_mem [NENT];
  logic [95:0] exp_rb = '0;

  always #5 clk = ~clk;

  meter_table_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .tbl_req(tbl_req), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .tbl_gnt(tbl_gnt), .tbl_rdata(ram_rdata),
    .rb_enable(rb_enable), .rb_mode(rb_mode), .rb_exponent(rb_exponent),
    .rb_mantissa(rb_mantissa)
  );

  assign tbl_gnt = tbl_req && gnt_r;

  // table model with random grant latency
  always @(posedge clk) begin
    gnt_r <= gnt_en && (($urandom % 3) == 0);
    if (tbl_req && tbl_gnt) begin
      grants++;
      last_we   <= tbl_we;
      last_addr <= tbl_addr;
      if (tbl_addr < NENT) begin
        if (tbl_we) mem[tbl_addr] <= tbl_wdata;
        else        ram_rdata     <= mem[tbl_addr];
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [95:0] act,
                       input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    while (!bus_ready) @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    while (!bus_ready) @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    while (!bus_ready) @(negedge clk);
  endtask

  function automatic logic [15:0] trig(input int i);
    return TBASE + 16'(4 * i);
  endfunction

  // check decoded outputs against word 2 of the expected read-back
  task automatic check_fields(input logic [95:0] e);
    logic [31:0] w2;
    w2 = e[95:64];
    check(rb_enable == w2[31], "R8 enable", 96'(rb_enable), 96'(w2[31]));
    check(rb_mode == w2[27:26], "R8 mode", 96'(rb_mode), 96'(w2[27:26]));
    check(rb_exponent == w2[13:8], "R8 exponent", 96'(rb_exponent), 96'(w2[13:8]));
    check(rb_mantissa == w2[25:14], "R8 mantissa", 96'(rb_mantissa), 96'(w2[25:14]));
  endtask

  task automatic check_rb(input string req);
    logic [31:0] d;
    for (int k = 0; k < 3; k++) begin
      bus_read(16'h0010 + 16'(4 * k), d);
      check(d == exp_rb[32*k +: 32], req, 96'(d), 96'(exp_rb[32*k +: 32]));
    end
    check_fields(exp_rb);
  endtask

  task automatic stage(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    bus_write(16'h0000, a);
    bus_write(16'h0004, b);
    bus_write(16'h0008, c);
  endtask

  task automatic commit(input int i, input logic [95:0] val);
    int g0;
    g0 = grants;
    bus_write(trig(i), 32'hDEAD_0000);
    if (i < NENT) begin
      check(bus_ready == 1'b0, "R5 ready low after trigger", 96'(bus_ready), 96'(0));
      wait_idle();
      check(last_we == 1'b1 && last_addr == 4'(i), "R3 write request",
            96'({last_we, last_addr}), 96'({1'b1, 4'(i)}));
      exp_mem[i] = val;
    end else begin
      check(bus_ready == 1'b1, "R7 oob write keeps ready", 96'(bus_ready), 96'(1));
      repeat (3) @(negedge clk);
      check(grants == g0, "R7 oob write no request", 96'(grants), 96'(g0));
    end
  endtask

  task automatic fetch(input int i);
    logic [31:0] d;
    int g0;
    g0 = grants;
    bus_read(trig(i), d);
    check(d == 32'h0, "R10 trigger read zero", 96'(d), 96'(0));
    if (i < NENT) begin
      check(bus_ready == 1'b0, "R5 ready low after fetch", 96'(bus_ready), 96'(0));
      wait_idle();
      check(last_we == 1'b0 && last_addr == 4'(i), "R4 fetch request",
            96'({last_we, last_addr}), 96'({1'b0, 4'(i)}));
      exp_rb = exp_mem[i];
      check_rb("R4 read-back words");
    end else begin
      check(bus_ready == 1'b1, "R7 oob read keeps ready", 96'(bus_ready), 96'(1));
      repeat (3) @(negedge clk);
      check(grants == g0, "R7 oob read no request", 96'(grants), 96'(g0));
      check_rb("R7 read-back unchanged");
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] d, a, b, c;
    logic [31:0] sa, sb, sc;
    void'($urandom(32'd1234));
    for (int k = 0; k < NENT; k++) begin mem[k] = '0; exp_mem[k] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(bus_ready == 1'b1, "R1 ready", 96'(bus_ready), 96'(1));
    check(tbl_req == 1'b0, "R1 no request", 96'(tbl_req), 96'(0));
    check(rb_enable == 1'b0, "R1 enable", 96'(rb_enable), 96'(0));
    for (int k = 0; k < 3; k++) begin
      bus_read(16'(4 * k), d);
      check(d == 0, "R1 staging zero", 96'(d), 96'(0));
      bus_read(16'h0010 + 16'(4 * k), d);
      check(d == 0, "R1 read-back zero", 96'(d), 96'(0));
    end

    // R2 staging write/readback
    stage(32'h1111_2222, 32'h3333_4444, 32'h8C12_3456);
    bus_read(16'h0000, d); check(d == 32'h1111_2222, "R2 word0", 96'(d), 96'(32'h1111_2222));
    bus_read(16'h0004, d); check(d == 32'h3333_4444, "R2 word1", 96'(d), 96'(32'h3333_4444));
    bus_read(16'h0008, d); check(d == 32'h8C12_3456, "R2 word2", 96'(d), 96'(32'h8C12_3456));

    // R10 unmapped reads
    bus_read(16'h000C, d); check(d == 0, "R10 unmapped 0x0C", 96'(d), 96'(0));
    bus_read(16'h0042, d); check(d == 0, "R10 misaligned", 96'(d), 96'(0));

    // R3/R4 directed commit and fetch, index 0 and last index
    commit(0, {32'h8C12_3456, 32'h3333_4444, 32'h1111_2222});
    commit(NENT - 1, {32'h8C12_3456, 32'h3333_4444, 32'h1111_2222});
    check(mem[NENT-1] == exp_mem[NENT-1], "R3 table contents",
          mem[NENT-1], exp_mem[NENT-1]);
    fetch(NENT - 1);

    // R6 staged data survives a fetch
    stage(32'hAAAA_0001, 32'hBBBB_0002, 32'hCCCC_0003);
    fetch(0);
    bus_read(16'h0000, d); check(d == 32'hAAAA_0001, "R6 word0 kept", 96'(d), 96'(32'hAAAA_0001));
    bus_read(16'h0008, d); check(d == 32'hCCCC_0003, "R6 word2 kept", 96'(d), 96'(32'hCCCC_0003));

    // R5 access while busy is ignored
    gnt_en = 1'b0;
    bus_write(trig(3), 32'h0);
    check(bus_ready == 1'b0, "R5 busy with grant held", 96'(bus_ready), 96'(0));
    bus_addr = 16'h0000; bus_wdata = 32'h5555_5555; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    gnt_en = 1'b1;
    wait_idle();
    exp_mem[3] = {32'hCCCC_0003, 32'hBBBB_0002, 32'hAAAA_0001};
    bus_read(16'h0000, d);
    check(d == 32'hAAAA_0001, "R5 blocked write ignored", 96'(d), 96'(32'hAAAA_0001));
    check(mem[3] == exp_mem[3], "R3 committed after long wait", mem[3], exp_mem[3]);

    // R9 invalidate with zero entry
    stage(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    commit(5, {96{1'b1}});
    fetch(5);
    check(rb_enable == 1'b1, "R9 enabled before clear", 96'(rb_enable), 96'(1));
    stage(32'h0, 32'h0, 32'h0);
    commit(5, 96'h0);
    fetch(5);
    check(rb_enable == 1'b0, "R9 enable cleared", 96'(rb_enable), 96'(0));

    // R7 directed out-of-range
    commit(NENT, 96'h0);
    fetch(NENT);
    fetch(15);

    // random mix
    for (int it = 0; it < 60; it++) begin
      int i;
      i = $urandom % 16;
      if (($urandom % 2) == 0) begin
        a = $urandom; b = $urandom; c = $urandom;
        stage(a, b, c);
        commit(i, {c, b, a});
      end else begin
        fetch(i);
      end
    end
    for (int k = 0; k < NENT; k++)
      check(mem[k] == exp_mem[k], "R3 final table", mem[k], exp_mem[k]);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule